// File: doc/BRIEF.md
# Comparator Timer Channel with Interrupt Routing

One channel of an event timer. It watches a shared free-running counter and compares it, on each tick strobe, against its own compare value. In one-shot mode a match raises one event and the compare value stays put. In periodic mode every match also moves the compare value forward by one period, so the channel keeps firing at a fixed rate without software help.

Each event leaves the channel in one of three ways: a one-cycle pulse on the routed pin, a level that stays asserted (backed by a status bit) until software clears it, or a message strobe carrying a 32-bit address and a 32-bit data word. The channel holds its own configuration word, comparator, period and message registers. It also guards them: read-only capability fields cannot be written, a route to a pin that the allowed-pin mask does not list is dropped to "unrouted", and a held level is released when the configuration change would otherwise leave it stuck. The shared counter and the register decoder sit outside this block.

Top module: `evt_timer_chan`

## Requirements
- R1: After reset the comparator reads 0xFFFFFFFF, the period reads 0, the level line and pulse are low, and the configuration word reads {ALLOW_MASK, 32'h0000_8010}. Bit 15 is message-capable, bit 4 is periodic-capable, and bit 5 is the size bit, which reads 0.
- R2: A configuration write changes only enable (bit 2), level type (bit 1), periodic type (bit 3), value-set (bit 6), route (bits 13:9) and message enable (bit 14). Bits 63:32, 15, 5 and 4 keep their values, and bit 8 (force 32-bit) always reads 0.
- R3: A configuration write whose route field selects a nonzero pin P with ALLOW_MASK[P]=0 stores route 0.
- R4: With bit 3 at 0, a comparator write loads the compare value directly, and the period reads 0 from the cycle after a write that clears bit 3.
- R5: With bit 3 at 1, a comparator write always loads the period and loads the compare value only if bit 6 is 1. Bit 6 reads 0 after any comparator write.
- R6: In periodic mode a match replaces the compare value C with C + period, modulo 2^32, which puts it one whole period past the counter.
- R7: With bit 1 at 0, a match on an enabled channel routed to a nonzero pin gives a pulse of exactly one clock cycle, with route_o showing the pin, and leaves the level line low.
- R8: With bit 1 at 1, a match sets the status bit and holds the level line. Further matches give no new event while it is set, and clr_i releases it.
- R9: A match with enable (bit 2) at 0 produces no pulse, level or message.
- R10: With message enable set, a match gives a one-cycle msg_valid_o with address = message register bits 63:32 and data = bits 31:0. route_o reads 0 and no pin event occurs.
- R11: A configuration write that clears enable, selects edge type, selects message mode or changes the route releases a set status bit.
- R12: With route 0 and message mode off, a match produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CW | Shared counter value |
| tick_i | input | 1 | Counter tick strobe; compare is evaluated when high |
| cfg_we | input | 1 | Write strobe for the writable low half of the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cmp_we | input | 1 | Comparator write strobe |
| cmp_wdata | input | CW | Comparator write data |
| msg_we | input | 2 | Half-word write strobes for the message register (bit 0 low, bit 1 high) |
| msg_wdata | input | 64 | Message register write data |
| clr_i | input | 1 | Clears the status bit and releases the level line |
| cfg_o | output | 64 | Configuration word as read back |
| cmp_o | output | CW | Active compare value |
| period_o | output | CW | Period register |
| route_o | output | 5 | Effective routed pin, 0 when unrouted or in message mode |
| irq_pulse_o | output | 1 | Edge event pulse |
| irq_level_o | output | 1 | Held level line, equal to the status bit |
| msg_valid_o | output | 1 | Message event strobe |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The bench builds the channel with CW = 32 and the default allowed-pin mask of pins 24 to 31, so routes to pins 24 and 25 are accepted and a route to pin 3 is rejected. The full 32-bit counter width lets a periodic rearm from 0xFFFFFFF0 wrap to 0x10. Every pulse, level rise and message the channel emits is checked against a queue of expected events, so a spurious event in the disabled, unrouted or status-held cases is reported as well.

// File: rtl/evt_timer_chan.sv
module evt_timer_chan #(
  parameter int          CW         = 32,
  parameter logic [31:0] ALLOW_MASK = 32'hFF00_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          tick_i,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic [1:0]    msg_we,
  input  logic [63:0]   msg_wdata,
  input  logic          clr_i,
  output logic [63:0]   cfg_o,
  output logic [CW-1:0] cmp_o,
  output logic [CW-1:0] period_o,
  output logic [4:0]    route_o,
  output logic          irq_pulse_o,
  output logic          irq_level_o,
  output logic          msg_valid_o,
  output logic [31:0]   msg_addr_o,
  output logic [31:0]   msg_data_o
);

  logic          lvl_q, en_q, per_q, vset_q, msgen_q, status_q, pulse_q, msgv_q;
  logic [4:0]    route_q;
  logic [CW-1:0] cmp_q, period_q;
  logic [63:0]   msg_q;

  wire unused_wbits = &{cfg_wdata[31:15], cfg_wdata[8:7], cfg_wdata[5:4], cfg_wdata[0]};

  wire [4:0] w_route = cfg_wdata[13:9];
  wire [4:0] n_route = (w_route != 5'd0 && !ALLOW_MASK[w_route]) ? 5'd0 : w_route;

  wire match  = tick_i && (count_i == cmp_q);
  wire fire   = match && en_q && !status_q;
  wire pinned = !msgen_q && (route_q != 5'd0);

  wire cfg_clear = status_q && cfg_we &&
                   (!cfg_wdata[2] || cfg_wdata[14] || !cfg_wdata[1] || n_route != route_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= 1'b0;
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      vset_q   <= 1'b0;
      msgen_q  <= 1'b0;
      route_q  <= 5'd0;
      cmp_q    <= '1;
      period_q <= '0;
      msg_q    <= '0;
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
      msgv_q   <= 1'b0;
    end else begin
      pulse_q <= fire && pinned && !lvl_q;
      msgv_q  <= fire && msgen_q;

      if (cfg_clear || clr_i)
        status_q <= 1'b0;
      else if (fire && pinned && lvl_q)
        status_q <= 1'b1;

      if (cfg_we) begin
        lvl_q   <= cfg_wdata[1];
        en_q    <= cfg_wdata[2];
        per_q   <= cfg_wdata[3];
        vset_q  <= cfg_wdata[6];
        route_q <= n_route;
        msgen_q <= cfg_wdata[14];
      end

      if (cmp_we) begin
        vset_q <= 1'b0;
        if (per_q) begin
          period_q <= cmp_wdata;
          if (vset_q) cmp_q <= cmp_wdata;
        end else begin
          cmp_q <= cmp_wdata;
        end
      end else if (match && per_q) begin
        cmp_q <= cmp_q + period_q;
      end

      if (cfg_we && !cfg_wdata[3])
        period_q <= '0;

      if (msg_we[0]) msg_q[31:0]  <= msg_wdata[31:0];
      if (msg_we[1]) msg_q[63:32] <= msg_wdata[63:32];
    end
  end

  assign cfg_o = {ALLOW_MASK, 16'h0, 1'b1, msgen_q, route_q, 1'b0, 1'b0,
                  vset_q, 1'b0, 1'b1, per_q, en_q, lvl_q, 1'b0};
  assign cmp_o       = cmp_q;
  assign period_o    = period_q;
  assign route_o     = msgen_q ? 5'd0 : route_q;
  assign irq_pulse_o = pulse_q;
  assign irq_level_o = status_q;
  assign msg_valid_o = msgv_q;
  assign msg_addr_o  = msg_q[63:32];
  assign msg_data_o  = msg_q[31:0];

  // R3
  route_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_o == 5'd0) || ALLOW_MASK[route_o]);

  // R8
  level_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level_o |-> (route_o != 5'd0 && cfg_o[2] && cfg_o[1]));

  // R10
  msg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> !irq_pulse_o);

  // R5
  vset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !cfg_we) |=> !cfg_o[6]);

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cmp_we) |=> $stable(cmp_o));

  // R4
  oneshot_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_o[3] |-> (period_o == '0));

endmodule

// File: tb/evt_timer_chan_bench.sv
module evt_timer_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] count_i = '0;
  logic        tick_i = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cmp_we = 1'b0;
  logic [31:0] cmp_wdata = '0;
  logic [1:0]  msg_we = '0;
  logic [63:0] msg_wdata = '0;
  logic        clr_i = 1'b0;
  logic [63:0] cfg_o;
  logic [31:0] cmp_o, period_o, msg_addr_o, msg_data_o;
  logic [4:0]  route_o;
  logic        irq_pulse_o, irq_level_o, msg_valid_o;

  evt_timer_chan u_evt_timer_chan (.*);

  always #10 clk = ~clk;

  typedef struct { int kind; logic [63:0] val; string tag; } ev_t;
  ev_t exp_q[$];
  int  n_chk = 0, n_fail = 0;
  logic prev_lvl = 1'b0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(int kind, logic [63:0] val, string tag);
    ev_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic got(int kind, logic [63:0] val);
    ev_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R9 unexpected event kind=%0d act=%h exp=none", kind, val);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.val !== val) begin
        n_fail++;
        $display("FAIL %s event act=%0d/%h exp=%0d/%h", e.tag, kind, val, e.kind, e.val);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_pulse_o) got(1, {59'd0, route_o});
      if (msg_valid_o) got(2, {msg_addr_o, msg_data_o});
      if (irq_level_o && !prev_lvl) got(3, {59'd0, route_o});
      prev_lvl = irq_level_o;
    end
  end

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic wcfg(logic [31:0] v);
    cfg_wdata = v; cfg_we = 1'b1; cyc(); cfg_we = 1'b0;
  endtask

  task automatic wcmp(logic [31:0] v);
    cmp_wdata = v; cmp_we = 1'b1; cyc(); cmp_we = 1'b0;
  endtask

  task automatic tickat(logic [31:0] v);
    count_i = v; tick_i = 1'b1; cyc(); tick_i = 1'b0; cyc();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=hung exp=done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 cfg", cfg_o, {32'hFF00_0000, 32'h0000_8010});
    check("R1 cmp", cmp_o, 32'hFFFF_FFFF);
    check("R1 period", period_o, 0);
    check("R1 level", irq_level_o, 0);

    // R2 read-only fields and force-32 bit
    wcfg(32'hFFFF_FFFF);
    check("R2 cfg all ones", cfg_o, {32'hFF00_0000, 32'h0000_FE5E});
    check("R2 force32", cfg_o[8], 0);

    // R3 illegal route dropped
    wcfg(32'h0000_0604);
    check("R3 cfg", cfg_o[31:0], 32'h0000_8014);
    check("R3 route", route_o, 0);

    // R4 one-shot write, R12 unrouted match
    wcmp(100);
    check("R4 cmp", cmp_o, 100);
    check("R4 period", period_o, 0);
    tickat(100);
    check("R12 cmp kept", cmp_o, 100);

    // R7 edge pulse
    wcfg(32'h0000_3004);
    wcmp(200);
    tickat(199);
    expect_ev(1, 24, "R7");
    count_i = 200; tick_i = 1'b1; cyc(); tick_i = 1'b0;
    check("R7 pulse high", irq_pulse_o, 1);
    cyc();
    check("R7 pulse one cycle", irq_pulse_o, 0);
    check("R7 no level", irq_level_o, 0);

    // R9 disabled
    wcfg(32'h0000_3000);
    tickat(200);
    check("R9 no level", irq_level_o, 0);

    // R8 level held, no re-event, clear
    wcfg(32'h0000_3006);
    expect_ev(3, 24, "R8");
    tickat(200);
    check("R8 level set", irq_level_o, 1);
    tickat(200);
    check("R8 still held", irq_level_o, 1);
    clr_i = 1'b1; cyc(); clr_i = 1'b0;
    check("R8 cleared", irq_level_o, 0);

    // R11 auto-clear on route change, disable, edge
    expect_ev(3, 24, "R11a");
    tickat(200);
    wcfg(32'h0000_3206);
    check("R11 route change", irq_level_o, 0);
    expect_ev(3, 25, "R11b");
    tickat(200);
    wcfg(32'h0000_3202);
    check("R11 disable", irq_level_o, 0);
    wcfg(32'h0000_3206);
    expect_ev(3, 25, "R11c");
    tickat(200);
    wcfg(32'h0000_3206);
    check("R11 same cfg keeps", irq_level_o, 1);
    wcfg(32'h0000_3204);
    check("R11 to edge", irq_level_o, 0);

    // R5 periodic comparator writes
    wcfg(32'h0000_304C);
    check("R5 cfg", cfg_o[31:0], 32'h0000_B05C);
    wcmp(1000);
    check("R5 cmp set", cmp_o, 1000);
    check("R5 period", period_o, 1000);
    check("R5 vset cleared", cfg_o[6], 0);
    wcmp(50);
    check("R5 period only", period_o, 50);
    check("R5 cmp kept", cmp_o, 1000);

    // R6 periodic rearm
    expect_ev(1, 24, "R6a");
    tickat(1000);
    check("R6 rearm", cmp_o, 1050);
    expect_ev(1, 24, "R6b");
    tickat(1050);
    check("R6 rearm2", cmp_o, 1100);
    wcfg(32'h0000_304C);
    wcmp(32'hFFFF_FFF0);
    wcmp(32'h20);
    check("R6 period", period_o, 32'h20);
    expect_ev(1, 24, "R6c");
    tickat(32'hFFFF_FFF0);
    check("R6 wrap", cmp_o, 32'h10);

    // R4 leaving periodic clears period
    wcfg(32'h0000_3004);
    check("R4 period cleared", period_o, 0);

    // R10 message delivery
    wcfg(32'h0000_7004);
    check("R10 route zero", route_o, 0);
    msg_wdata = 64'hFEE0_1000_0000_0041; msg_we = 2'b11; cyc(); msg_we = 2'b00;
    wcmp(300);
    expect_ev(2, 64'hFEE0_1000_0000_0041, "R10");
    tickat(300);
    check("R10 no level", irq_level_o, 0);

    cyc();
    check("R10 all events seen", exp_q.size(), 0);
    finish_run();
  end
endmodule